// File: doc/BRIEF.md
# Hash Accelerator Register Front End

This block is the memory-mapped register slave in front of a multi-algorithm hash engine. Software loads a chaining context of eight digest words, a running byte count, an operating mode and a byte length. It then writes sixteen data words. The last data word starts one block. When the block is done, the front end writes the new digest words and the new byte count back into the same registers. Software can therefore save a context between blocks and restore it later. A mode bit chooses whether a block starts from the algorithm's standard initial values or from the loaded digest words. A second mode bit marks the final, padded block.

The round logic is not part of this block. It is stood in for by a stub that takes a fixed number of cycles and applies a simple, documented word function. Completion is reported through sticky status flags, which are cleared by writing ones. Each flag has its own enable. A global gate decides whether the flags reach the interrupt line. A DMA request can pace the data words while bytes of the programmed length are still outstanding.

The control state machine has three states:
- `ST_IDLE`: waiting for a launching write.
- `ST_RUN`: the stub latency is counting down.
- `ST_COMMIT`: the one cycle in which results are written back.

It has four transitions:
- IDLE to RUN on a launching write.
- RUN to RUN while the countdown is not zero.
- RUN to COMMIT when the countdown reaches zero.
- COMMIT to IDLE unconditionally.

Top module: `hash_regfront`

## Requirements
- R1: After reset, every register reads 0, except the status register at 0x118, which reads 0x2 (input ready). Both `irq` and `dma_req` are low after reset.
- R2: The register map is as follows. Accesses whose byte address bits 1:0 are not zero are ignored, and unmapped addresses read 0.

  | Offset | Register | Stored bits |
  |---|---|---|
  | 0x20+4i, i=0..7 | Digest word i | all 32 |
  | 0x40 | Byte count | all 32 |
  | 0x44 | Mode | bits 4:1 |
  | 0x48 | Length | all 32 |
  | 0x80+4i, i=0..15 | Data word i | all 32 |
  | 0x110 | Configuration | bits 2, 3, 6 and 7 |
  | 0x11C | Interrupt enable | bits 3:0 |

  Unstored bits read 0. The mode fields are: bits 2:1 hold the algorithm (0 = MD5, 1 = SHA-1, 2 = SHA-224, 3 = SHA-256), bit 3 selects the standard initial values, and bit 4 marks the closing block.
- R3: The status register at 0x118 holds four flags: bit 0 output ready, bit 1 input ready, bit 2 partial ready, bit 3 context ready. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A hardware set in the same cycle wins over the clear.
- R4: A write to data word 15 (0xBC) launches a block only while input ready is set. The launch clears input ready. Without input ready, the write only stores the word. Bit 0 of 0x114 reads 1 while a block is in progress.
- R5: A block's results appear LAT+1 cycles after the edge of the launching write. At that point output ready, input ready and context ready are set. Partial ready is also set when the close bit was 0 at launch.
- R6: Each valid result word i is (B xor D[i]) + D[i+8], where D holds the data words including the launching write. B is the standard initial value of word i for the chosen algorithm when mode bit 3 is 1, and digest word i otherwise.
- R7: Writing the length loads a remaining-byte count. Each launch consumes min(remaining, 64) bytes from it. The byte count becomes its value at launch plus that amount.
- R8: `irq` is high exactly when configuration bit 2 is 1 and some status bit is set together with its enable bit.
- R9: `dma_req` is high exactly when configuration bit 3 is 1, input ready is set and the remaining-byte count is not zero.
- R10: After a block, digest words at and beyond the valid count read 0. The valid count is 4 for MD5, 5 for SHA-1, 7 for SHA-224 and 8 for SHA-256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the read |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | Data-word transfer request |

## Verification
Read data is due one edge after the read strobe. Status flags, digest words and the count change on the edge LAT+1 cycles after the launching write. Clearing a flag by write and the resulting change in `irq` or `dma_req` are visible right after the write edge. The bench steps its model at every falling edge, applying the edge that just passed with the bus values that were held across it. It then compares `irq`, `dma_req` and any pending read against the model. Stimulus changes only just after the falling edge, so every comparison lands on the cycle in which each result is due.

// File: rtl/hrf_pkg.sv
package hrf_pkg;

    typedef enum logic [1:0] {
        ALG_MD5    = 2'd0,
        ALG_SHA1   = 2'd1,
        ALG_SHA224 = 2'd2,
        ALG_SHA256 = 2'd3
    } alg_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_COMMIT = 2'd2
    } fsm_e;

    localparam int WORD_W    = 32;
    localparam int NDIG      = 8;
    localparam int NDIN      = 2 * NDIG;
    localparam int BLK_BYTES = 4 * NDIN;
    localparam int NFLAG     = 4;

    // status flag positions
    localparam int SB_OUT  = 0;
    localparam int SB_IN   = 1;
    localparam int SB_PART = 2;
    localparam int SB_CTX  = 3;

    // configuration bit positions and write mask
    localparam int CB_IRQ = 2;
    localparam int CB_DMA = 3;
    localparam logic [7:0] CFG_MASK = 8'hCC;

    // byte offsets
    localparam logic [11:0] A_DIG0 = 12'h020;
    localparam logic [11:0] A_CNT  = 12'h040;
    localparam logic [11:0] A_MODE = 12'h044;
    localparam logic [11:0] A_LEN  = 12'h048;
    localparam logic [11:0] A_DIN0 = 12'h080;
    localparam logic [11:0] A_CFG  = 12'h110;
    localparam logic [11:0] A_SYS  = 12'h114;
    localparam logic [11:0] A_IST  = 12'h118;
    localparam logic [11:0] A_IEN  = 12'h11C;

    function automatic int unsigned valid_words(alg_e a);
        unique case (a)
            ALG_MD5:    return 4;
            ALG_SHA1:   return 5;
            ALG_SHA224: return 7;
            default:    return 8;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] init_word(alg_e a, int unsigned i);
        logic [WORD_W-1:0] w;
        w = '0;
        unique case (a)
            ALG_MD5, ALG_SHA1: begin
                case (i)
                    0: w = 32'h67452301;
                    1: w = 32'hefcdab89;
                    2: w = 32'h98badcfe;
                    3: w = 32'h10325476;
                    4: w = (a == ALG_SHA1) ? 32'hc3d2e1f0 : 32'h0;
                    default: w = '0;
                endcase
            end
            ALG_SHA224: begin
                case (i)
                    0: w = 32'hc1059ed8;
                    1: w = 32'h367cd507;
                    2: w = 32'h3070dd17;
                    3: w = 32'hf70e5939;
                    4: w = 32'hffc00b31;
                    5: w = 32'h68581511;
                    6: w = 32'h64f98fa7;
                    default: w = 32'hbefa4fa4;
                endcase
            end
            default: begin
                case (i)
                    0: w = 32'h6a09e667;
                    1: w = 32'hbb67ae85;
                    2: w = 32'h3c6ef372;
                    3: w = 32'ha54ff53a;
                    4: w = 32'h510e527f;
                    5: w = 32'h9b05688c;
                    6: w = 32'h1f83d9ab;
                    default: w = 32'h5be0cd19;
                endcase
            end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/hrf_ctrl.sv
module hrf_ctrl
    import hrf_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch_req,
    output logic start,
    output logic commit,
    output logic busy
);
    localparam int CW = $clog2(LAT + 1);

    fsm_e          state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (launch_req) begin
                    state_d = ST_RUN;
                    cnt_d   = CW'(LAT - 1);
                end
            end
            ST_RUN: begin
                if (cnt_q == '0) state_d = ST_COMMIT;
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        start  = (state_q == ST_IDLE) && launch_req;
        commit = (state_q == ST_COMMIT);
        busy   = (state_q != ST_IDLE);
    end

    // R5: the countdown ending leads straight into write-back
    p_run_to_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && cnt_q == '0) |=> commit);

    // R5: write-back lasts exactly one cycle
    p_commit_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

endmodule

// File: rtl/hrf_core_stub.sv
module hrf_core_stub
    import hrf_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  alg_e                          alg,
    input  logic                          use_init,
    input  logic                          close_in,
    input  logic [NDIG-1:0][WORD_W-1:0]   dig_in,
    input  logic [NDIN-1:0][WORD_W-1:0]   din,
    input  logic [WORD_W-1:0]             cnt_in,
    input  logic [WORD_W-1:0]             blk_len,
    output logic [NDIG-1:0][WORD_W-1:0]   res_dig,
    output logic [WORD_W-1:0]             res_cnt,
    output logic                          res_close
);
    logic [NDIG-1:0][WORD_W-1:0] calc;

    for (genvar g = 0; g < NDIG; g++) begin : g_word
        logic [WORD_W-1:0] base;
        always_comb begin
            base    = use_init ? init_word(alg, g) : dig_in[g];
            calc[g] = (g < valid_words(alg)) ? ((base ^ din[g]) + din[g+NDIG]) : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_dig   <= '0;
            res_cnt   <= '0;
            res_close <= 1'b0;
        end else if (start) begin
            res_dig   <= calc;
            res_cnt   <= cnt_in + blk_len;
            res_close <= close_in;
        end
    end

endmodule

// File: rtl/hrf_irq.sv
module hrf_irq
    import hrf_pkg::*;
#(
    parameter int          NB      = NFLAG,
    parameter logic [NB-1:0] RST_VAL = NB'(1 << SB_IN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          w1c_we,
    input  logic [NB-1:0] w1c_bits,
    input  logic [NB-1:0] hw_set,
    input  logic [NB-1:0] hw_clr,
    input  logic [NB-1:0] en,
    input  logic          gate,
    output logic [NB-1:0] st,
    output logic          irq
);
    logic [NB-1:0] clr_mask;

    assign clr_mask = (w1c_we ? w1c_bits : '0) | hw_clr;

    for (genvar b = 0; b < NB; b++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         st[b] <= RST_VAL[b];
            else if (hw_set[b]) st[b] <= 1'b1;
            else if (clr_mask[b]) st[b] <= 1'b0;
        end
    end

    assign irq = gate && |(st & en);

endmodule

// File: rtl/hash_regfront.sv
module hash_regfront
    import hrf_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int LAT    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              dma_req
);
    localparam int WA_W = ADDR_W - 2;

    logic [WA_W-1:0] waddr;
    logic            aligned, wr_ok;
    logic            dig_hit, din_hit;
    logic            hit_cnt, hit_mode, hit_len, hit_cfg, hit_sys, hit_ist, hit_ien;

    logic [NDIG-1:0][WORD_W-1:0] dig_q;
    logic [NDIN-1:0][WORD_W-1:0] din_q, din_d;
    logic [WORD_W-1:0]           count_q, len_q, rem_q, blk_len, rd_val;
    logic [3:0]                  mode_q;
    logic [7:0]                  cfg_q;
    logic [NFLAG-1:0]            en_q, ist_q, hw_set, hw_clr;

    logic start, commit, busy, launch_req;
    logic [NDIG-1:0][WORD_W-1:0] res_dig;
    logic [WORD_W-1:0]           res_cnt;
    logic                        res_close;

    // ---------------- decode ----------------
    assign waddr    = bus_addr[ADDR_W-1:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign wr_ok    = bus_wr && aligned;
    assign dig_hit  = aligned && (waddr[WA_W-1:3] == (WA_W-3)'(A_DIG0 >> 5));
    assign din_hit  = aligned && (waddr[WA_W-1:4] == (WA_W-4)'(A_DIN0 >> 6));
    assign hit_cnt  = aligned && (waddr == WA_W'(A_CNT  >> 2));
    assign hit_mode = aligned && (waddr == WA_W'(A_MODE >> 2));
    assign hit_len  = aligned && (waddr == WA_W'(A_LEN  >> 2));
    assign hit_cfg  = aligned && (waddr == WA_W'(A_CFG  >> 2));
    assign hit_sys  = aligned && (waddr == WA_W'(A_SYS  >> 2));
    assign hit_ist  = aligned && (waddr == WA_W'(A_IST  >> 2));
    assign hit_ien  = aligned && (waddr == WA_W'(A_IEN  >> 2));

    // ---------------- digest context ----------------
    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  dig_q[g] <= '0;
            else if (commit)                             dig_q[g] <= res_dig[g];
            else if (bus_wr && dig_hit && waddr[2:0] == 3'(g)) dig_q[g] <= bus_wdata;
        end
    end

    // ---------------- data words ----------------
    for (genvar g = 0; g < NDIN; g++) begin : g_din
        assign din_d[g] = (bus_wr && din_hit && waddr[3:0] == 4'(g)) ? bus_wdata : din_q[g];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) din_q[g] <= '0;
            else        din_q[g] <= din_d[g];
        end
    end

    assign launch_req = bus_wr && din_hit && (waddr[3:0] == 4'(NDIN - 1)) && ist_q[SB_IN];
    assign blk_len    = (rem_q > WORD_W'(BLK_BYTES)) ? WORD_W'(BLK_BYTES) : rem_q;

    // ---------------- scalar registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            mode_q  <= '0;
            len_q   <= '0;
            rem_q   <= '0;
            cfg_q   <= '0;
            en_q    <= '0;
        end else begin
            if (commit)                count_q <= res_cnt;
            else if (wr_ok && hit_cnt) count_q <= bus_wdata;
            if (wr_ok && hit_mode) mode_q <= bus_wdata[4:1];
            if (wr_ok && hit_cfg)  cfg_q  <= bus_wdata[7:0] & CFG_MASK;
            if (wr_ok && hit_ien)  en_q   <= bus_wdata[NFLAG-1:0];
            if (start) begin
                rem_q <= rem_q - blk_len;
            end else if (wr_ok && hit_len) begin
                len_q <= bus_wdata;
                rem_q <= bus_wdata;
            end
        end
    end

    // ---------------- sub-blocks ----------------
    hrf_ctrl #(.LAT(LAT)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_req (launch_req),
        .start      (start),
        .commit     (commit),
        .busy       (busy)
    );

    hrf_core_stub u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .alg       (alg_e'(mode_q[1:0])),
        .use_init  (mode_q[2]),
        .close_in  (mode_q[3]),
        .dig_in    (dig_q),
        .din       (din_d),
        .cnt_in    (count_q),
        .blk_len   (blk_len),
        .res_dig   (res_dig),
        .res_cnt   (res_cnt),
        .res_close (res_close)
    );

    always_comb begin
        hw_set = '0;
        hw_clr = '0;
        if (commit) begin
            hw_set[SB_OUT]  = 1'b1;
            hw_set[SB_IN]   = 1'b1;
            hw_set[SB_CTX]  = 1'b1;
            hw_set[SB_PART] = !res_close;
        end
        if (start) hw_clr[SB_IN] = 1'b1;
    end

    hrf_irq #(.NB(NFLAG)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .w1c_we   (wr_ok && hit_ist),
        .w1c_bits (bus_wdata[NFLAG-1:0]),
        .hw_set   (hw_set),
        .hw_clr   (hw_clr),
        .en       (en_q),
        .gate     (cfg_q[CB_IRQ]),
        .st       (ist_q),
        .irq      (irq)
    );

    assign dma_req = cfg_q[CB_DMA] && ist_q[SB_IN] && (rem_q != '0);

    // ---------------- read path ----------------
    always_comb begin
        rd_val = '0;
        if (dig_hit)       rd_val = dig_q[waddr[2:0]];
        else if (din_hit)  rd_val = din_q[waddr[3:0]];
        else if (hit_cnt)  rd_val = count_q;
        else if (hit_mode) rd_val = {27'b0, mode_q, 1'b0};
        else if (hit_len)  rd_val = len_q;
        else if (hit_cfg)  rd_val = {24'b0, cfg_q};
        else if (hit_sys)  rd_val = {31'b0, busy};
        else if (hit_ist)  rd_val = {{(32-NFLAG){1'b0}}, ist_q};
        else if (hit_ien)  rd_val = {{(32-NFLAG){1'b0}}, en_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end

    // ---------------- assertions ----------------
    // R4: a block starts only with input ready set
    p_start_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ist_q[SB_IN]);

    // R4: input ready drops after a launch
    p_ready_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ist_q[SB_IN]);

    // R5: completion raises output, input and context ready
    p_flags_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (ist_q[SB_OUT] && ist_q[SB_IN] && ist_q[SB_CTX]));

    // R7: the byte count takes the engine's count at write-back
    p_count_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (count_q == $past(res_cnt)));

    // R9: no transfer request while a block is in flight
    p_dma_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !dma_req);

endmodule

// File: tb/hash_regfront_tb_top.sv
module hash_regfront_tb_top;
    localparam int LAT = 4;

    logic        clk = 1'b0, rst_n = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, dma;

    always #5 clk = ~clk;

    hash_regfront #(.ADDR_W(12), .LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq), .dma_req(dma)
    );

    int n_chk = 0, n_fail = 0;
    string tag = "";

    // behavioural model
    logic [31:0] m_dig[8], m_din[16], r_dig[8];
    logic [31:0] m_cnt, m_len, m_rem, r_cnt;
    logic [3:0]  m_mode, m_st, m_en;
    logic [7:0]  m_cfg;
    logic        r_close;
    int          m_busy;

    function automatic logic [31:0] iv(int a, int i);
        logic [31:0] md[5] = '{32'h67452301, 32'hefcdab89, 32'h98badcfe, 32'h10325476, 32'hc3d2e1f0};
        logic [31:0] s224[8] = '{32'hc1059ed8, 32'h367cd507, 32'h3070dd17, 32'hf70e5939,
                                 32'hffc00b31, 32'h68581511, 32'h64f98fa7, 32'hbefa4fa4};
        logic [31:0] s256[8] = '{32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                                 32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
        if (a == 0) return (i < 4) ? md[i] : 32'h0;
        if (a == 1) return (i < 5) ? md[i] : 32'h0;
        if (a == 2) return s224[i];
        return s256[i];
    endfunction

    function automatic int nwords(int a);
        return (a == 0) ? 4 : (a == 1) ? 5 : (a == 2) ? 7 : 8;
    endfunction

    function automatic logic [31:0] mread(logic [11:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        if (a >= 12'h020 && a <= 12'h03C) return m_dig[a[4:2]];
        if (a >= 12'h080 && a <= 12'h0BC) return m_din[a[5:2]];
        case (a)
            12'h040: return m_cnt;
            12'h044: return {27'b0, m_mode, 1'b0};
            12'h048: return m_len;
            12'h110: return {24'b0, m_cfg};
            12'h114: return {31'b0, (m_busy > 0)};
            12'h118: return {28'b0, m_st};
            12'h11C: return {28'b0, m_en};
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", t, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++)  begin m_dig[i] = '0; r_dig[i] = '0; end
        for (int i = 0; i < 16; i++) m_din[i] = '0;
        m_cnt = '0; m_len = '0; m_rem = '0; r_cnt = '0; r_close = 1'b0;
        m_mode = '0; m_st = 4'b0010; m_en = '0; m_cfg = '0; m_busy = 0;
    endtask

    task automatic model_step();
        logic        launch, commit_now;
        logic [3:0]  w1c, setb, clrb;
        logic [31:0] blk, base;
        int          alg;
        if (rd) chk(tag, rdata, mread(addr));
        launch     = wr && addr == 12'h0BC && m_st[1] && m_busy == 0;
        w1c        = (wr && addr == 12'h118) ? wdata[3:0] : 4'b0;
        setb       = '0;
        clrb       = '0;
        commit_now = 1'b0;
        if (m_busy > 0) begin
            m_busy--;
            if (m_busy == 0) commit_now = 1'b1;
        end
        if (wr && addr[1:0] == 2'b00) begin
            if (addr >= 12'h020 && addr <= 12'h03C) m_dig[addr[4:2]] = wdata;
            if (addr >= 12'h080 && addr <= 12'h0BC) m_din[addr[5:2]] = wdata;
            case (addr)
                12'h040: m_cnt  = wdata;
                12'h044: m_mode = wdata[4:1];
                12'h048: begin m_len = wdata; m_rem = wdata; end
                12'h110: m_cfg  = wdata[7:0] & 8'hCC;
                12'h11C: m_en   = wdata[3:0];
                default: ;
            endcase
        end
        if (launch) begin
            alg = int'(m_mode[1:0]);
            blk = (m_rem > 64) ? 32'd64 : m_rem;
            for (int i = 0; i < 8; i++) begin
                base     = m_mode[2] ? iv(alg, i) : m_dig[i];
                r_dig[i] = (i < nwords(alg)) ? ((base ^ m_din[i]) + m_din[i+8]) : 32'h0;
            end
            r_cnt   = m_cnt + blk;
            r_close = m_mode[3];
            m_rem   = m_rem - blk;
            m_busy  = LAT + 1;
            clrb[1] = 1'b1;
        end
        if (commit_now) begin
            for (int i = 0; i < 8; i++) m_dig[i] = r_dig[i];
            m_cnt = r_cnt;
            setb  = {1'b1, !r_close, 1'b1, 1'b1};
        end
        m_st = (m_st & ~w1c & ~clrb) | setb;
    endtask

    always @(negedge clk) begin
        if (!rst_n) model_reset();
        else begin
            model_step();
            chk("R8 irq", {31'b0, irq}, {31'b0, m_cfg[2] && |(m_st & m_en)});
            chk("R9 dma_req", {31'b0, dma}, {31'b0, m_cfg[3] && m_st[1] && (m_rem != 0)});
        end
    end

    // bus tasks: called just after a falling edge
    task automatic wr_t(logic [11:0] a, logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic rd_t(logic [11:0] a, string t);
        tag = t; rd = 1'b1; addr = a;
        @(negedge clk); #1;
        rd = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic load_block(logic [3:0] mode, logic [31:0] len, logic [31:0] seed, bit setlen);
        wr_t(12'h044, {27'b0, mode, 1'b0});
        if (setlen) wr_t(12'h048, len);
        for (int i = 0; i < 16; i++)
            wr_t(12'h080 + 12'(4 * i), seed ^ (32'h9E3779B9 * (i + 1)));
    endtask

    task automatic dump();
        rd_t(12'h118, "R5 status after block");
        rd_t(12'h040, "R7 byte count");
        for (int i = 0; i < 8; i++) rd_t(12'h020 + 12'(4 * i), "R6 R10 digest word");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R4 watchdog act=%0d exp=%0d", 20000, 0);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        rd_t(12'h118, "R1 status reset");
        rd_t(12'h040, "R1 count reset");
        rd_t(12'h044, "R1 mode reset");
        rd_t(12'h110, "R1 config reset");
        rd_t(12'h11C, "R1 enable reset");
        rd_t(12'h114, "R1 busy reset");
        rd_t(12'h020, "R1 digest reset");

        // R2: map and masks
        wr_t(12'h044, 32'hFFFF_FFFF); rd_t(12'h044, "R2 mode mask");
        wr_t(12'h110, 32'hFFFF_FFFF); rd_t(12'h110, "R2 config mask");
        wr_t(12'h11C, 32'hFFFF_FFFF); rd_t(12'h11C, "R2 enable mask");
        wr_t(12'h024, 32'h1234_5678); rd_t(12'h024, "R2 digest word rw");
        wr_t(12'h048, 32'h0000_0040); rd_t(12'h048, "R2 length rw");
        wr_t(12'h042, 32'hDEAD_BEEF); rd_t(12'h040, "R2 misaligned write ignored");
        rd_t(12'h0C8, "R2 unmapped read");
        wr_t(12'h110, 32'h0); wr_t(12'h11C, 32'h0);

        // block on MD5 from standard values; busy seen right after launch
        load_block(4'b0100, 32'd64, 32'h0000_1111, 1'b1);
        rd_t(12'h114, "R4 busy during block");
        idle(LAT + 2);
        dump();

        // SHA-256 continuing from loaded digest
        load_block(4'b0011, 32'd64, 32'h2222_0000, 1'b1);
        idle(LAT + 3);
        dump();

        // SHA-1 closing block: partial ready stays clear
        wr_t(12'h118, 32'hD);
        rd_t(12'h118, "R3 write-one clear");
        load_block(4'b1101, 32'd64, 32'h3333_3333, 1'b1);
        idle(LAT + 3);
        dump();

        // SHA-224 short block of 20 bytes
        load_block(4'b0110, 32'd20, 32'h4444_AAAA, 1'b1);
        idle(LAT + 3);
        dump();

        // R8: interrupt gating
        wr_t(12'h11C, 32'hF); idle(2);
        wr_t(12'h110, 32'h4); idle(2);
        wr_t(12'h118, 32'hD); idle(2);
        wr_t(12'h11C, 32'h1); idle(2);
        wr_t(12'h110, 32'h0); idle(1);

        // R9: transfer requests over a 130-byte message
        wr_t(12'h110, 32'h8);
        wr_t(12'h048, 32'd130);
        idle(2);
        for (int b = 0; b < 3; b++) begin
            load_block(4'b0100, 32'd0, 32'h5555_0000 + b, 1'b0);
            idle(LAT + 3);
        end
        rd_t(12'h040, "R7 count after three transfers");
        rd_t(12'h048, "R7 length kept");
        wr_t(12'h110, 32'h0);

        // R4: no launch without input ready
        wr_t(12'h118, 32'h2);
        rd_t(12'h118, "R3 input ready cleared");
        wr_t(12'h0BC, 32'h0000_0055);
        idle(2);
        rd_t(12'h114, "R4 no launch busy");
        rd_t(12'h0BC, "R4 word stored");
        rd_t(12'h118, "R4 status unchanged");
        idle(LAT + 2);
        rd_t(12'h020, "R4 digest unchanged");

        // second reset
        rst_n = 1'b0; idle(2); rst_n = 1'b1;
        rd_t(12'h118, "R1 status after reset");
        rd_t(12'h040, "R1 count after reset");

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule